// File: doc/BRIEF.md
# Register Rename Status Table

This block holds a small bank of floating-point registers. Each register carries a producer tag naming the reservation station that will next write it. An instruction being issued reads up to two source registers. For each source the block returns one of two things: the register value with a zero tag when no write is pending, or the producer tag when a write is still outstanding. In the same cycle the block records which station becomes the producer of the instruction's destination register.

The block also watches the shared result bus, where a finishing station broadcasts its tag and its data. A register takes the broadcast data only if its producer tag still equals the broadcast tag. A register renamed by a younger instruction therefore drops an older result on its own, so the issue logic never stalls on write-after-write or write-after-read hazards.

Source reads see the bus in the cycle it broadcasts, so an operand that arrives in the issue cycle is never lost.

Top module: `rename_table`

## Requirements
- R1: Reset, synchronous and active low, clears every producer tag to zero and loads register i with the value 32'h0000_A000 + i (eight registers, 3-bit index, 4-bit tag, 32-bit data).
- R2: A read port addressing a register whose tag is zero returns that register's value with tag zero, in the same cycle, combinationally.
- R3: An issue with a nonzero tag sets the destination's producer tag to that tag from the next clock edge; reads in the issue cycle still see the state from before the issue.
- R4: A broadcast with a valid, nonzero tag writes its data into every register whose tag equals it and clears their tags at the next edge; all other registers keep their value and tag.
- R5: A read whose register tag equals a valid, nonzero broadcast tag in the same cycle returns the broadcast data with tag zero; a read port never returns the tag being broadcast.
- R6: A register renamed to a younger tag ignores a later broadcast of its older tag and keeps waiting on the younger one.
- R7: When an issue renames a register in the same cycle that a broadcast matches its old tag, the new tag is kept and the register is not marked valid; it later takes the data broadcast under the new tag.
- R8: A broadcast with the valid bit low or with tag zero, and an issue with tag zero, change no register and no tag.
- R9: The two read ports are independent and may address the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rdAddrA | input | 3 | Source register index, port A |
| rdAddrB | input | 3 | Source register index, port B |
| rdValA | output | 32 | Value for port A, meaningful when rdTagA is zero |
| rdTagA | output | 4 | Producer tag for port A, zero when the value is valid |
| rdValB | output | 32 | Value for port B, meaningful when rdTagB is zero |
| rdTagB | output | 4 | Producer tag for port B, zero when the value is valid |
| issueEn | input | 1 | Rename the destination register this cycle |
| issueDst | input | 3 | Destination register index |
| issueTag | input | 4 | Station that will produce the destination |
| cdbValid | input | 1 | Result bus carries a result this cycle |
| cdbTag | input | 4 | Tag of the broadcasting station |
| cdbData | input | 32 | Broadcast result data |

## Verification
Two pairs of functions can fall in the same cycle. A source read can coincide with a broadcast of that source's producer tag, and a destination rename can coincide with a broadcast of the destination's old tag. The vector table schedules a broadcast in the very cycle a read or a rename targets the matching register. It judges the read outputs before that cycle's edge, then judges the surviving tag and the value in the following cycles, including a wrong-tag and a zero-tag broadcast that must leave everything unchanged.

// File: rtl/rename_table_pkg.sv
package rename_table_pkg;
  localparam int NumRegs = 8;
  localparam int TagW    = 4;
  localparam int DataW   = 32;
  localparam int AddrW   = $clog2(NumRegs);
  localparam int NumRdPorts = 2;
  localparam logic [DataW-1:0] ResetBase = 32'h0000_A000;

  typedef logic [TagW-1:0]  tag_t;
  typedef logic [DataW-1:0] data_t;
  typedef logic [AddrW-1:0] addr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NumRegs-1:0]    commitWe; // take broadcast data into register i
    logic [NumRdPorts-1:0] fwdSel;   // read port p returns broadcast data
  } strobe_t;
endpackage

// File: rtl/rename_table_ctrl.sv
module rename_table_ctrl
  import rename_table_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  addr_t   rdAddrA,
  input  addr_t   rdAddrB,
  input  logic    issueEn,
  input  addr_t   issueDst,
  input  tag_t    issueTag,
  input  logic    cdbValid,
  input  tag_t    cdbTag,
  output tag_t    rdTagA,
  output tag_t    rdTagB,
  output strobe_t strobes
);
  tag_t qTag [NumRegs];
  logic cdbLive;
  logic issueLive;
  logic [NumRegs-1:0] matchHit;
  logic [NumRegs-1:0] renameHit;
  addr_t portAddr [NumRdPorts];
  tag_t  portTag  [NumRdPorts];

  assign cdbLive   = cdbValid && (cdbTag != '0);
  assign issueLive = issueEn && (issueTag != '0);

  for (genvar i = 0; i < NumRegs; i++) begin : g_reg
    assign matchHit[i]  = cdbLive && (qTag[i] == cdbTag);
    assign renameHit[i] = issueLive && (issueDst == addr_t'(i));
    // a same-cycle rename takes priority over the commit of the old tag
    assign strobes.commitWe[i] = matchHit[i] && !renameHit[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        qTag[i] <= '0;
      end else if (renameHit[i]) begin
        qTag[i] <= issueTag;
      end else if (matchHit[i]) begin
        qTag[i] <= '0;
      end
    end
  end

  assign portAddr[0] = rdAddrA;
  assign portAddr[1] = rdAddrB;

  for (genvar p = 0; p < NumRdPorts; p++) begin : g_port
    logic pending;
    assign pending = qTag[portAddr[p]] != '0;
    assign strobes.fwdSel[p] = pending && cdbLive && (qTag[portAddr[p]] == cdbTag);
    assign portTag[p] = strobes.fwdSel[p] ? '0 : qTag[portAddr[p]];
  end

  assign rdTagA = portTag[0];
  assign rdTagB = portTag[1];
endmodule

// File: rtl/rename_table_dp.sv
module rename_table_dp
  import rename_table_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  input  data_t   cdbData,
  input  addr_t   rdAddrA,
  input  addr_t   rdAddrB,
  output data_t   rdValA,
  output data_t   rdValB
);
  data_t regVal  [NumRegs];
  addr_t portAddr [NumRdPorts];
  data_t portVal  [NumRdPorts];

  for (genvar i = 0; i < NumRegs; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regVal[i] <= ResetBase + data_t'(i);
      end else if (strobes.commitWe[i]) begin
        regVal[i] <= cdbData;
      end
    end
  end

  assign portAddr[0] = rdAddrA;
  assign portAddr[1] = rdAddrB;

  for (genvar p = 0; p < NumRdPorts; p++) begin : g_port
    assign portVal[p] = strobes.fwdSel[p] ? cdbData : regVal[portAddr[p]];
  end

  assign rdValA = portVal[0];
  assign rdValB = portVal[1];
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rename_table_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  rdAddrA,
  input  logic [2:0]  rdAddrB,
  output logic [31:0] rdValA,
  output logic [3:0]  rdTagA,
  output logic [31:0] rdValB,
  output logic [3:0]  rdTagB,
  input  logic        issueEn,
  input  logic [2:0]  issueDst,
  input  logic [3:0]  issueTag,
  input  logic        cdbValid,
  input  logic [3:0]  cdbTag,
  input  logic [31:0] cdbData
);
  strobe_t strobes;

  rename_table_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .issueEn  (issueEn),
    .issueDst (issueDst),
    .issueTag (issueTag),
    .cdbValid (cdbValid),
    .cdbTag   (cdbTag),
    .rdTagA   (rdTagA),
    .rdTagB   (rdTagB),
    .strobes  (strobes)
  );

  rename_table_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cdbData (cdbData),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .rdValA  (rdValA),
    .rdValB  (rdValB)
  );
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  rdAddrA,
  input logic [31:0] rdValA,
  input logic [3:0]  rdTagA,
  input logic [3:0]  rdTagB,
  input logic        issueEn,
  input logic [2:0]  issueDst,
  input logic [3:0]  issueTag,
  input logic        cdbValid,
  input logic [3:0]  cdbTag,
  input logic [31:0] cdbData
);
  // R3
  issue_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(issueEn) && $past(issueTag) != 4'd0 &&
     $past(issueDst) == rdAddrA && !(cdbValid && cdbTag == $past(issueTag)))
    |-> rdTagA == $past(issueTag));

  // R5
  fwd_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(issueEn) && $past(issueTag) != 4'd0 &&
     $past(issueDst) == rdAddrA && cdbValid && cdbTag == $past(issueTag))
    |-> (rdTagA == 4'd0 && rdValA == cdbData));

  // R5
  no_bcast_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cdbValid && cdbTag != 4'd0) |-> (rdTagA != cdbTag && rdTagB != cdbTag));

  // R8
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cdbValid) && !$past(issueEn) && !cdbValid && $stable(rdAddrA))
    |-> ($stable(rdTagA) && $stable(rdValA)));

  // R6
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(issueEn) && $past(issueTag) != 4'd0 && $past(cdbValid) &&
     $past(cdbTag) != $past(issueTag) && $past(issueDst) == rdAddrA && !cdbValid)
    |-> rdTagA == $past(issueTag));
endmodule

bind rename_table rename_table_chk i_chk (.*);

// File: tb/test_rename_table.sv
module test_rename_table;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  rdAddrA, rdAddrB;
  logic [31:0] rdValA, rdValB;
  logic [3:0]  rdTagA, rdTagB;
  logic        issueEn;
  logic [2:0]  issueDst;
  logic [3:0]  issueTag;
  logic        cdbValid;
  logic [3:0]  cdbTag;
  logic [31:0] cdbData;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk; // 125 MHz

  rename_table i_rename_table (.*);

  typedef struct packed {
    logic        iEn;
    logic [2:0]  iDst;
    logic [3:0]  iTag;
    logic        cV;
    logic [3:0]  cTag;
    logic [31:0] cData;
    logic [2:0]  rA;
    logic [2:0]  rB;
    logic [3:0]  eTagA;
    logic [31:0] eValA;
    logic [3:0]  eTagB;
    logic [31:0] eValB;
    logic [3:0]  req;
  } vec_t;

  localparam int NumVec = 24;
  // values are checked only where the expected tag is zero
  localparam vec_t Vecs [NumVec] = '{
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd0,3'd7, 4'd0, 32'hA000,4'd0, 32'hA007,4'd1}, // R1 R9
    '{1'b1,3'd2,4'd5,  1'b0,4'd0, 32'h0,    3'd2,3'd2, 4'd0, 32'hA002,4'd0, 32'hA002,4'd3}, // R3 old state
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd2,3'd3, 4'd5, 32'h0,   4'd0, 32'hA003,4'd3}, // R3 R2
    '{1'b0,3'd0,4'd0,  1'b1,4'd5, 32'h1111, 3'd2,3'd4, 4'd0, 32'h1111,4'd0, 32'hA004,4'd5}, // R5
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd2,3'd1, 4'd0, 32'h1111,4'd0, 32'hA001,4'd4}, // R4
    '{1'b1,3'd3,4'd6,  1'b0,4'd0, 32'h0,    3'd3,3'd0, 4'd0, 32'hA003,4'd0, 32'hA000,4'd3},
    '{1'b1,3'd3,4'd7,  1'b0,4'd0, 32'h0,    3'd3,3'd0, 4'd6, 32'h0,   4'd0, 32'hA000,4'd6}, // R6 rename again
    '{1'b0,3'd0,4'd0,  1'b1,4'd6, 32'h2222, 3'd3,3'd3, 4'd7, 32'h0,   4'd7, 32'h0,   4'd6}, // R6 stale bcast
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd3,3'd2, 4'd7, 32'h0,   4'd0, 32'h1111,4'd6},
    '{1'b0,3'd0,4'd0,  1'b1,4'd7, 32'h3333, 3'd3,3'd3, 4'd0, 32'h3333,4'd0, 32'h3333,4'd5}, // R5 R9
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd3,3'd0, 4'd0, 32'h3333,4'd0, 32'hA000,4'd4},
    '{1'b1,3'd4,4'd9,  1'b0,4'd0, 32'h0,    3'd4,3'd5, 4'd0, 32'hA004,4'd0, 32'hA005,4'd3},
    '{1'b1,3'd4,4'd10, 1'b1,4'd9, 32'h4444, 3'd4,3'd5, 4'd0, 32'h4444,4'd0, 32'hA005,4'd7}, // R7 collide
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd4,3'd4, 4'd10,32'h0,   4'd10,32'h0,   4'd7}, // R7 new tag kept
    '{1'b0,3'd0,4'd0,  1'b1,4'd0, 32'h9999, 3'd4,3'd6, 4'd10,32'h0,   4'd0, 32'hA006,4'd8}, // R8 tag zero
    '{1'b0,3'd0,4'd0,  1'b0,4'd10,32'h7777, 3'd4,3'd6, 4'd10,32'h0,   4'd0, 32'hA006,4'd8}, // R8 valid low
    '{1'b1,3'd6,4'd0,  1'b0,4'd0, 32'h0,    3'd6,3'd6, 4'd0, 32'hA006,4'd0, 32'hA006,4'd8}, // R8 zero issue
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd6,3'd4, 4'd0, 32'hA006,4'd10,32'h0,   4'd8},
    '{1'b1,3'd0,4'd12, 1'b0,4'd0, 32'h0,    3'd0,3'd1, 4'd0, 32'hA000,4'd0, 32'hA001,4'd3},
    '{1'b1,3'd1,4'd12, 1'b0,4'd0, 32'h0,    3'd0,3'd1, 4'd12,32'h0,   4'd0, 32'hA001,4'd3},
    '{1'b0,3'd0,4'd0,  1'b1,4'd12,32'h6666, 3'd0,3'd1, 4'd0, 32'h6666,4'd0, 32'h6666,4'd5},
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd0,3'd1, 4'd0, 32'h6666,4'd0, 32'h6666,4'd4}, // R4 all matches
    '{1'b0,3'd0,4'd0,  1'b1,4'd10,32'h5555, 3'd4,3'd2, 4'd0, 32'h5555,4'd0, 32'h1111,4'd7},
    '{1'b0,3'd0,4'd0,  1'b0,4'd0, 32'h0,    3'd4,3'd2, 4'd0, 32'h5555,4'd0, 32'h1111,4'd4}  // R4 others kept
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    issueEn = 1'b0; issueDst = '0; issueTag = '0;
    cdbValid = 1'b0; cdbTag = '0; cdbData = '0;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    rdAddrA = '0; rdAddrB = '0;
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    for (int v = 0; v < NumVec; v++) begin
      issueEn = Vecs[v].iEn; issueDst = Vecs[v].iDst; issueTag = Vecs[v].iTag;
      cdbValid = Vecs[v].cV; cdbTag = Vecs[v].cTag; cdbData = Vecs[v].cData;
      rdAddrA = Vecs[v].rA; rdAddrB = Vecs[v].rB;
      #3;
      check($sformatf("vec %0d tagA", v), int'(Vecs[v].req), 32'(rdTagA), 32'(Vecs[v].eTagA));
      check($sformatf("vec %0d tagB", v), int'(Vecs[v].req), 32'(rdTagB), 32'(Vecs[v].eTagB));
      if (Vecs[v].eTagA == 4'd0)
        check($sformatf("vec %0d valA", v), int'(Vecs[v].req), rdValA, Vecs[v].eValA);
      if (Vecs[v].eTagB == 4'd0)
        check($sformatf("vec %0d valB", v), int'(Vecs[v].req), rdValB, Vecs[v].eValB);
      @(negedge clk);
    end

    // R1: pending tag and written values are cleared by reset
    idleInputs();
    issueEn = 1'b1; issueDst = 3'd5; issueTag = 4'd3;
    @(negedge clk);
    idleInputs();
    rdAddrA = 3'd5;
    #3 check("pending before reset", 3, 32'(rdTagA), 32'd3);
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < 8; r++) begin
      rdAddrA = 3'(r);
      rdAddrB = 3'(7 - r);
      #3;
      check($sformatf("reset tag reg %0d", r), 1, 32'(rdTagA), 32'd0);
      check($sformatf("reset val reg %0d", r), 1, rdValA, 32'hA000 + 32'(r));
      check($sformatf("reset val port B reg %0d", 7 - r), 9, rdValB, 32'hA000 + 32'(7 - r));
      @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule